// File: doc/BRIEF.md
# EDO DRAM Cycle-Type Decoder

This block sits on the device side of an EDO DRAM interface and watches the four active-low strobes: row strobe, column strobe, write enable and output enable. A fast system clock samples them. Each strobe passes through a synchronizer chain, and edges are detected on the synchronized copies. A classifier then names every memory cycle from the order in which the strobe edges arrive. The cycle can be a read, an early write, a delayed write, a read-modify-write, a write whose output state is indeterminate, a row-only refresh, a column-before-row refresh or a hidden refresh. A separate flag marks accesses that continue a page, meaning they are not the first column access of the row period.

Beside the cycle code, the block models the extended-data-out output buffer. Read data becomes valid once the access latency has elapsed. It stays driven after the column strobe rises, and it goes away only when both row and column strobes are high. Output enable going high or write enable going low turns it off earlier. The block flags two protocol faults. The first is a write that drives data while the output buffer may still be enabled. The second is a row strobe held low beyond a maximum count of clock cycles.

All timing is counted in sampled clock cycles. Cell storage and analog timing are not modelled.

Top module: `edo_cycle_decoder`

## Requirements
- R1: After reset, cyc_type_o is 0 (no cycle), and cyc_stb_o, cyc_page_o, dout_en_o, err_conflict_o and err_ras_long_o are all 0.
- R2: Each classification pulses cyc_stb_o for one cycle and loads cyc_type_o, which holds its value until the next classification. One row period with one access produces exactly one pulse. Codes: 0 none, 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 indeterminate write, 6 row-only refresh, 7 column-before-row refresh, 8 hidden refresh.
- R3: If the column strobe is low when the row strobe falls, and no hidden refresh is armed, the cycle is reported as code 7.
- R4: A row-low period in which the column strobe never falls is reported as code 6 when the row strobe rises.
- R5: If write enable is low when the column strobe falls during a row-low period, the access is reported as code 2 at that edge, and dout_en_o stays 0 for that access.
- R6: Let d be the number of sampled cycles by which write enable falls after the column strobe falls, within one open access. If 1 ≤ d ≤ ACC_CYC, the code is 3 when output enable is high and 5 when it is low. If d > ACC_CYC, the code is 4.
- R7: err_conflict_o sets in two cases: a late write (codes 3, 4 or 5) is classified while output enable is low, or output enable falls while write enable is low after a late write in the same column-low period. It holds until the next falling row strobe.
- R8: An access that ends on a rising column strobe or a rising row strobe without a write-enable fall is reported as code 1.
- R9: dout_en_o rises once a read access has been open for more than ACC_CYC cycles. It stays high after the column strobe rises, and falls once both row and column strobes are high. It is 0 whenever output enable is high or write enable is low.
- R10: When the row strobe rises while the column strobe is low after a column access, the next row fall with the column strobe still low is reported as code 8, and the read data stays driven.
- R11: cyc_page_o is 1 for an access that is not the first column access of its row-low period, and 0 for the first access and for all refresh codes.
- R12: err_ras_long_o is 1 while the row strobe has been low for more than RAS_MAX_CYC cycles, and clears when the row strobe rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| cyc_type_o | output | 4 | Code of the most recent classified cycle |
| cyc_stb_o | output | 1 | One-cycle pulse on each classification |
| cyc_page_o | output | 1 | Latest classified access was a page continuation |
| dout_en_o | output | 1 | Modelled data output buffer is driving |
| err_conflict_o | output | 1 | Write data may collide with driven output |
| err_ras_long_o | output | 1 | Row strobe held low too long |

## Verification
The bench sweeps the delay from the column fall to the write-enable fall across both output-enable levels. This pins down the boundary between early write, delayed or indeterminate write, and read-modify-write. If the access counter were off by one, the cycle at d = ACC_CYC or d = ACC_CYC+1 would be misreported. The bench also checks the extended-data-out hold: output data must survive the column strobe rising in page mode and a hidden refresh. A design that released the output on the first rising strobe instead of the later one would drop dout_en_o there. Other corners covered are hidden versus plain column-before-row refresh, the page flag on the second access of a row, the conflict raised by output enable falling during a delayed write, and the row-low limit on both sides of its threshold.

// File: rtl/edo_dec_pkg.sv
package edo_dec_pkg;

   typedef enum logic [3:0] {
      CYC_NONE     = 4'd0,
      CYC_READ     = 4'd1,
      CYC_EARLY_WR = 4'd2,
      CYC_LATE_WR  = 4'd3,
      CYC_RMW      = 4'd4,
      CYC_INDET    = 4'd5,
      CYC_ROR      = 4'd6,
      CYC_CBR      = 4'd7,
      CYC_HIDDEN   = 4'd8
   } cyc_e;

   typedef enum logic [1:0] {
      RM_IDLE = 2'd0,
      RM_ROW  = 2'd1,
      RM_CBR  = 2'd2
   } ras_mode_e;

   localparam int STB_RAS = 0;
   localparam int STB_CAS = 1;
   localparam int STB_WE  = 2;
   localparam int STB_OE  = 3;
   localparam int NUM_STB = 4;

endpackage

// File: rtl/edo_strobe_sync.sv
module edo_strobe_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] lvl_o,
   output logic [WIDTH-1:0] prev_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("edo_strobe_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("edo_strobe_sync: WIDTH must be at least 1");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      logic              last;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '1;
            last  <= 1'b1;
         end else begin
            chain <= {chain[STAGES-2:0], async_i[g]};
            last  <= chain[STAGES-1];
         end
      end

      assign lvl_o[g]  = chain[STAGES-1];
      assign prev_o[g] = last;
   end

endmodule

// File: rtl/edo_ras_timer.sv
module edo_ras_timer #(
   parameter int MAX_CYC = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ras_low_i,
   output logic long_o
);

   if (MAX_CYC < 1) begin : g_bad_max
      $error("edo_ras_timer: MAX_CYC must be at least 1");
   end

   localparam int CW = $clog2(MAX_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(MAX_CYC);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         long_o <= 1'b0;
      end else begin
         if (!ras_low_i) begin
            cnt <= '0;
         end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
         end
         long_o <= ras_low_i && (cnt == LIMIT);
      end
   end

endmodule

// File: rtl/edo_cycle_fsm.sv
module edo_cycle_fsm
   import edo_dec_pkg::*;
#(
   parameter int ACC_CYC = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_STB-1:0] lvl_i,
   input  logic [NUM_STB-1:0] prev_i,
   output logic               emit_o,
   output cyc_e               emit_type_o,
   output logic               emit_page_o,
   output logic               dout_en_o,
   output logic               conflict_o
);

   if (ACC_CYC < 1) begin : g_bad_acc
      $error("edo_cycle_fsm: ACC_CYC must be at least 1");
   end

   localparam int CW = $clog2(ACC_CYC + 1);
   localparam logic [CW-1:0] ACC_LIM = CW'(ACC_CYC);

   // edge and level decode on synchronized strobes (high = inactive)
   logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, oe_fall;
   logic we_lo, oe_lo, cas_lo;
   assign ras_fall = prev_i[STB_RAS]  & ~lvl_i[STB_RAS];
   assign ras_rise = ~prev_i[STB_RAS] &  lvl_i[STB_RAS];
   assign cas_fall = prev_i[STB_CAS]  & ~lvl_i[STB_CAS];
   assign cas_rise = ~prev_i[STB_CAS] &  lvl_i[STB_CAS];
   assign we_fall  = prev_i[STB_WE]   & ~lvl_i[STB_WE];
   assign oe_fall  = prev_i[STB_OE]   & ~lvl_i[STB_OE];
   assign we_lo    = ~lvl_i[STB_WE];
   assign oe_lo    = ~lvl_i[STB_OE];
   assign cas_lo   = ~lvl_i[STB_CAS];

   ras_mode_e     mode;
   logic          acc_open;
   logic          any_acc;
   logic          page_cur;
   logic [CW-1:0] acc_cnt;
   logic          hid_arm;
   logic          late_wr;
   logic          data_vld;
   logic          acc_done;

   assign acc_done = acc_open && (acc_cnt == ACC_LIM);

   // classification of the current sampled cycle
   always_comb begin
      emit_o      = 1'b0;
      emit_type_o = CYC_NONE;
      emit_page_o = 1'b0;
      if (ras_fall) begin
         if (cas_lo) begin
            emit_o      = 1'b1;
            emit_type_o = hid_arm ? CYC_HIDDEN : CYC_CBR;
         end
      end else if (ras_rise) begin
         if (mode == RM_ROW) begin
            if (acc_open) begin
               emit_o      = 1'b1;
               emit_type_o = CYC_READ;
               emit_page_o = page_cur;
            end else if (!any_acc) begin
               emit_o      = 1'b1;
               emit_type_o = CYC_ROR;
            end
         end
      end else if (mode == RM_ROW) begin
         if (cas_fall) begin
            if (we_lo) begin
               emit_o      = 1'b1;
               emit_type_o = CYC_EARLY_WR;
               emit_page_o = any_acc;
            end
         end else if (acc_open) begin
            if (we_fall) begin
               emit_o      = 1'b1;
               emit_page_o = page_cur;
               if (acc_done)   emit_type_o = CYC_RMW;
               else if (oe_lo) emit_type_o = CYC_INDET;
               else            emit_type_o = CYC_LATE_WR;
            end else if (cas_rise) begin
               emit_o      = 1'b1;
               emit_type_o = CYC_READ;
               emit_page_o = page_cur;
            end
         end
      end
   end

   // cycle state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= RM_IDLE;
         acc_open <= 1'b0;
         any_acc  <= 1'b0;
         page_cur <= 1'b0;
         acc_cnt  <= '0;
         hid_arm  <= 1'b0;
         late_wr  <= 1'b0;
         conflict_o <= 1'b0;
      end else begin
         if (ras_fall) begin
            mode       <= cas_lo ? RM_CBR : RM_ROW;
            acc_open   <= 1'b0;
            any_acc    <= 1'b0;
            conflict_o <= 1'b0;
         end else if (ras_rise) begin
            mode     <= RM_IDLE;
            acc_open <= 1'b0;
            if (cas_lo && (mode == RM_ROW) && any_acc) begin
               hid_arm <= 1'b1;
            end
         end else if (mode == RM_ROW) begin
            if (cas_fall) begin
               any_acc  <= 1'b1;
               page_cur <= any_acc;
               acc_cnt  <= '0;
               acc_open <= !we_lo;
            end else if (acc_open) begin
               if (we_fall) begin
                  acc_open <= 1'b0;
                  late_wr  <= 1'b1;
                  if (oe_lo) conflict_o <= 1'b1;
               end else if (cas_rise) begin
                  acc_open <= 1'b0;
               end else if (!acc_done) begin
                  acc_cnt <= acc_cnt + 1'b1;
               end
            end
         end
         if (late_wr && oe_fall && we_lo && cas_lo) begin
            conflict_o <= 1'b1;
         end
         if (cas_rise) begin
            hid_arm <= 1'b0;
            late_wr <= 1'b0;
         end
      end
   end

   // extended-data-out buffer model
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_vld  <= 1'b0;
         dout_en_o <= 1'b0;
      end else begin
         if (we_lo || (lvl_i[STB_RAS] && lvl_i[STB_CAS])) begin
            data_vld <= 1'b0;
         end else if (acc_done) begin
            data_vld <= 1'b1;
         end
         dout_en_o <= data_vld && oe_lo && !we_lo;
      end
   end

endmodule

// File: rtl/edo_cycle_decoder.sv
module edo_cycle_decoder
   import edo_dec_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ACC_CYC     = 3,
   parameter int RAS_MAX_CYC = 5000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ras_n,
   input  logic       cas_n,
   input  logic       we_n,
   input  logic       oe_n,
   output logic [3:0] cyc_type_o,
   output logic       cyc_stb_o,
   output logic       cyc_page_o,
   output logic       dout_en_o,
   output logic       err_conflict_o,
   output logic       err_ras_long_o
);

   logic [NUM_STB-1:0] stb_raw;
   logic [NUM_STB-1:0] stb_lvl;
   logic [NUM_STB-1:0] stb_prev;

   always_comb begin
      stb_raw          = '1;
      stb_raw[STB_RAS] = ras_n;
      stb_raw[STB_CAS] = cas_n;
      stb_raw[STB_WE]  = we_n;
      stb_raw[STB_OE]  = oe_n;
   end

   edo_strobe_sync #(
      .WIDTH  (NUM_STB),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (stb_raw),
      .lvl_o   (stb_lvl),
      .prev_o  (stb_prev)
   );

   edo_ras_timer #(
      .MAX_CYC (RAS_MAX_CYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .ras_low_i (~stb_lvl[STB_RAS]),
      .long_o    (err_ras_long_o)
   );

   logic emit;
   cyc_e emit_type;
   logic emit_page;

   edo_cycle_fsm #(
      .ACC_CYC (ACC_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .lvl_i       (stb_lvl),
      .prev_i      (stb_prev),
      .emit_o      (emit),
      .emit_type_o (emit_type),
      .emit_page_o (emit_page),
      .dout_en_o   (dout_en_o),
      .conflict_o  (err_conflict_o)
   );

   cyc_e type_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         type_q     <= CYC_NONE;
         cyc_stb_o  <= 1'b0;
         cyc_page_o <= 1'b0;
      end else begin
         cyc_stb_o <= emit;
         if (emit) begin
            type_q     <= emit_type;
            cyc_page_o <= emit_page;
         end
      end
   end

   assign cyc_type_o = type_q;

endmodule

// File: rtl/edo_cycle_decoder_chk.sv
module edo_cycle_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ras_s,
   input logic       cas_s,
   input logic       we_s,
   input logic       oe_s,
   input logic [3:0] cyc_type,
   input logic       cyc_stb,
   input logic       cyc_page,
   input logic       dout_en,
   input logic       err_long
);

   // R2: a strobe always carries a real cycle code
   a_r2_stb_has_code: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_stb |-> (cyc_type != 4'd0));

   // R11: page continuations are never refresh codes
   a_r11_page_not_refresh: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_stb && cyc_page) |-> (cyc_type >= 4'd1 && cyc_type <= 4'd5));

   // R9: output driven only when output enable was low a cycle before
   a_r9_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> $past(!oe_s));

   // R9: write enable low turns the output off
   a_r9_we_gates: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> $past(we_s));

   // R9: both strobes high for two cycles leaves the output off
   a_r9_later_rise_off: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ras_s && cas_s, 1) && $past(ras_s && cas_s, 2)) |-> !dout_en);

   // R12: the row-low flag needs the row strobe low
   a_r12_long_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
      err_long |-> $past(!ras_s));

endmodule

bind edo_cycle_decoder edo_cycle_decoder_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ras_s    (stb_lvl[edo_dec_pkg::STB_RAS]),
   .cas_s    (stb_lvl[edo_dec_pkg::STB_CAS]),
   .we_s     (stb_lvl[edo_dec_pkg::STB_WE]),
   .oe_s     (stb_lvl[edo_dec_pkg::STB_OE]),
   .cyc_type (cyc_type_o),
   .cyc_stb  (cyc_stb_o),
   .cyc_page (cyc_page_o),
   .dout_en  (dout_en_o),
   .err_long (err_ras_long_o)
);

// File: tb/tb_edo_cycle_decoder.sv
module tb_edo_cycle_decoder;

   localparam int ACC = 3;
   localparam int RMAX = 60;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
   logic [3:0] cyc_type_o;
   logic cyc_stb_o, cyc_page_o, dout_en_o, err_conflict_o, err_ras_long_o;

   int tests = 0;
   int fails = 0;
   int stb_cnt = 0;

   always #10 clk = ~clk;

   edo_cycle_decoder #(
      .SYNC_STAGES (2),
      .ACC_CYC     (ACC),
      .RAS_MAX_CYC (RMAX)
   ) dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .ras_n          (ras_n),
      .cas_n          (cas_n),
      .we_n           (we_n),
      .oe_n           (oe_n),
      .cyc_type_o     (cyc_type_o),
      .cyc_stb_o      (cyc_stb_o),
      .cyc_page_o     (cyc_page_o),
      .dout_en_o      (dout_en_o),
      .err_conflict_o (err_conflict_o),
      .err_ras_long_o (err_ras_long_o)
   );

   always @(negedge clk) if (rst_n && cyc_stb_o) stb_cnt++;

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int late_code(input int d, input bit oe_low);
      if (d == 0) return 2;
      if (d <= ACC) return oe_low ? 5 : 3;
      return 4;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int s0;
      wt(3);
      // R1 reset state
      chk("R1 type", int'(cyc_type_o), 0);
      chk("R1 stb", int'(cyc_stb_o), 0);
      chk("R1 dout", int'(dout_en_o), 0);
      chk("R1 conflict", int'(err_conflict_o), 0);
      chk("R1 long", int'(err_ras_long_o), 0);
      rst_n = 1'b1;
      wt(4);

      // R8, R9, R2: single read with EDO hold
      s0 = stb_cnt;
      ras_n = 0; wt(6);
      cas_n = 0; wt(8);
      chk("R9 dout after access", int'(dout_en_o), 1);
      cas_n = 1; wt(6);
      chk("R8 read code", int'(cyc_type_o), 1);
      chk("R11 first access", int'(cyc_page_o), 0);
      chk("R9 held after cas rise", int'(dout_en_o), 1);
      ras_n = 1; wt(6);
      chk("R9 off after later rise", int'(dout_en_o), 0);
      chk("R2 one strobe", stb_cnt - s0, 1);

      // R4 row-only refresh
      ras_n = 0; wt(6); ras_n = 1; wt(6);
      chk("R4 ror code", int'(cyc_type_o), 6);

      // R3 cbr refresh
      cas_n = 0; wt(6); ras_n = 0; wt(6);
      chk("R3 cbr code", int'(cyc_type_o), 7);
      chk("R9 no data in cbr", int'(dout_en_o), 0);
      ras_n = 1; wt(4); cas_n = 1; wt(6);

      // R5 early write
      ras_n = 0; wt(6); we_n = 0; wt(2); cas_n = 0; wt(8);
      chk("R5 early code", int'(cyc_type_o), 2);
      chk("R5 dout off", int'(dout_en_o), 0);
      cas_n = 1; we_n = 1; wt(6);
      chk("R5 dout off after", int'(dout_en_o), 0);
      ras_n = 1; wt(6);

      // R9 OE disables mid-read, re-enables
      ras_n = 0; wt(6); cas_n = 0; wt(8);
      oe_n = 1; wt(5);
      chk("R9 oe high off", int'(dout_en_o), 0);
      oe_n = 0; wt(5);
      chk("R9 oe low on", int'(dout_en_o), 1);

      // R11 page mode continuation, EDO hold across precharge
      cas_n = 1; wt(5);
      chk("R9 hold in precharge", int'(dout_en_o), 1);
      cas_n = 0; wt(8); cas_n = 1; wt(6);
      chk("R8 page read code", int'(cyc_type_o), 1);
      chk("R11 page flag", int'(cyc_page_o), 1);
      we_n = 0; wt(2); cas_n = 0; wt(6);
      chk("R5 page early code", int'(cyc_type_o), 2);
      chk("R11 page early flag", int'(cyc_page_o), 1);
      chk("R5 page early dout", int'(dout_en_o), 0);
      cas_n = 1; we_n = 1; wt(3); ras_n = 1; wt(6);

      // R10 hidden refresh
      ras_n = 0; wt(6); cas_n = 0; wt(8);
      ras_n = 1; wt(6);
      chk("R8 read closed by ras", int'(cyc_type_o), 1);
      chk("R10 data held", int'(dout_en_o), 1);
      ras_n = 0; wt(6);
      chk("R10 hidden code", int'(cyc_type_o), 8);
      chk("R11 refresh no page", int'(cyc_page_o), 0);
      chk("R10 data still driven", int'(dout_en_o), 1);
      ras_n = 1; wt(6);
      chk("R10 held after ras", int'(dout_en_o), 1);
      cas_n = 1; wt(6);
      chk("R9 off after cas", int'(dout_en_o), 0);

      // R7 OE falls during delayed write
      oe_n = 1; ras_n = 0; wt(6); cas_n = 0; wt(1); we_n = 0; wt(6);
      chk("R6 delayed code", int'(cyc_type_o), 3);
      chk("R7 no conflict yet", int'(err_conflict_o), 0);
      oe_n = 0; wt(6);
      chk("R7 oe fall conflict", int'(err_conflict_o), 1);
      chk("R9 dout off during write", int'(dout_en_o), 0);
      cas_n = 1; we_n = 1; wt(3); ras_n = 1; wt(6);
      chk("R7 held to ras fall", int'(err_conflict_o), 1);
      ras_n = 0; wt(6);
      chk("R7 cleared", int'(err_conflict_o), 0);
      ras_n = 1; wt(6);
      chk("R4 ror after clear", int'(cyc_type_o), 6);

      // R6/R7 sweep of write-enable delay and output enable
      for (int oe = 0; oe < 2; oe++) begin
         for (int d = 0; d <= ACC + 3; d++) begin
            oe_n = (oe == 0);
            ras_n = 0; wt(6);
            cas_n = 0;
            if (d == 0) we_n = 0;
            else begin wt(d); we_n = 0; end
            wt(6);
            chk($sformatf("R6 code d=%0d oe_low=%0d", d, oe), int'(cyc_type_o),
                late_code(d, oe == 1));
            chk($sformatf("R7 conflict d=%0d oe_low=%0d", d, oe), int'(err_conflict_o),
                (d > 0 && oe == 1) ? 1 : 0);
            cas_n = 1; we_n = 1; wt(3); ras_n = 1; oe_n = 0; wt(6);
         end
      end

      // R12 row low too long
      ras_n = 0; wt(RMAX - 10);
      chk("R12 below limit", int'(err_ras_long_o), 0);
      wt(20);
      chk("R12 above limit", int'(err_ras_long_o), 1);
      ras_n = 1; wt(6);
      chk("R12 cleared", int'(err_ras_long_o), 0);
      chk("R4 long ror code", int'(cyc_type_o), 6);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule